// File: doc/BRIEF.md
# Integer Arithmetic and Compare Unit

This unit is the integer execute stage of a small load-store RISC core. It takes two register operands, or one register operand and a 16-bit immediate, together with an operation code and a shift amount. It returns a 32-bit result and an overflow flag.

The operations are:

- add and subtract, each in a checked form that reports signed overflow and a modular form that never does;
- less-than tests under signed and unsigned interpretation, which return 0 or 1;
- a left shift by a 5-bit amount.

Every operation that uses a second operand can take it from the immediate instead of the register. The overflow flag is only a report: the result always carries the wrapped value, and whatever reacts to the overflow sits outside this unit.

The unit is combinational. A parameter adds one register stage on the result and the flag, and that stage is cleared by a synchronous active-low reset.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (checked add) returns the low 32 bits of A + B and raises the overflow flag exactly when both operands have the same sign and the result sign differs from it.
- R2: Operation code 2 (checked subtract) returns the low 32 bits of A - B and raises the overflow flag exactly when the operands have different signs and the result sign differs from the sign of A.
- R3: Operation codes 1 (modular add) and 3 (modular subtract) return the same wrapped sum or difference as codes 0 and 2, and the overflow flag stays 0 for every operand pair.
- R4: When the immediate select is 1, the 16-bit immediate is sign-extended from its bit 15 to 32 bits and replaces operand B, and the register operand B has no effect on the outputs.
- R5: Operation code 4 returns 1 when A is less than B as two's-complement numbers and 0 otherwise, including when they are equal.
- R6: Operation code 5 returns 1 when A is less than B as unsigned numbers and 0 otherwise. In the immediate form the immediate is sign-extended first, so immediate 0xFFFF compares as 0xFFFFFFFF.
- R7: Operation code 6 returns A shifted left by the 5-bit shift amount, with zeros filling the vacated low bits. A shift amount of 0 returns A unchanged.
- R8: Operation codes 7 to 15 return a result of 0 with the overflow flag at 0, and only codes 0 and 2 can ever raise the overflow flag.
- R9: With the output register enabled, the result and the flag appear one clock after the inputs. Both read 0 after any clock edge at which the reset is held low.
- R10: With the output register disabled, the result and the flag follow the inputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_sel | input | 4 | Operation code (0 add, 1 modular add, 2 subtract, 3 modular subtract, 4 signed less-than, 5 unsigned less-than, 6 shift left) |
| use_imm | input | 1 | 1 takes operand B from the sign-extended immediate |
| src_a | input | 32 | Register operand A |
| src_b | input | 32 | Register operand B |
| imm16 | input | 16 | Two's-complement immediate |
| shamt | input | 5 | Left-shift amount |
| result | output | 32 | Operation result |
| ovf_flag | output | 1 | Signed overflow of the checked add or subtract |

## Verification
The bench builds two copies side by side from the same stimulus: one with the output register enabled (OUT_REG=1) and one purely combinational (OUT_REG=0), both at 32 data bits and 16 immediate bits.

The combinational copy is sampled one nanosecond after each input change. The registered copy is sampled one clock later. This brings both the same-cycle path and the one-cycle latency and reset clearing within reach in a single run.

The chosen widths put the sign-boundary operands in reach: 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and the immediate values 0x7FFF, 0x8000 and 0xFFFF. These are the cases where the checked and modular forms, and the signed and unsigned compares, give different answers.

// File: rtl/int_alu_pkg.sv
// Package: shared operation codes and default widths for the integer ALU.
// Assumes a 4-bit operation field decoded by the instruction decoder upstream.
package int_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,   // checked add
        OP_ADDM = 4'd1,   // modular add
        OP_SUB  = 4'd2,   // checked subtract
        OP_SUBM = 4'd3,   // modular subtract
        OP_LTS  = 4'd4,   // signed less-than
        OP_LTU  = 4'd5,   // unsigned less-than
        OP_SHL  = 4'd6    // logical shift left
    } alu_op_e;

endpackage

// File: rtl/int_alu_opsel.sv
// Module: chooses operand B, either the register value or the sign-extended
// immediate. Assumes IMM_W <= DATA_W.
module int_alu_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // Replicate the immediate sign bit across the upper bits.
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    // Select the second operand.
    always_comb begin
        opnd_b = use_imm ? imm_ext : reg_b;
    end
endmodule

// File: rtl/int_alu_addsub.sv
// Module: shared adder for add and subtract, with signed overflow detection.
// Subtraction is done as A + ~B + 1. Overflow is reported only when chk_ovf
// is set; the sum itself always wraps.
module int_alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    input  logic              chk_ovf,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              same_sign;
    logic              sign_flip;

    // Invert B for subtraction; the carry-in below completes the negation.
    always_comb begin
        b_eff = do_sub ? ~b : b;
    end

    // Modular sum with carry-in for subtraction.
    always_comb begin
        sum = a + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
    end

    // Signed overflow: effective operands agree in sign and the result does not.
    always_comb begin
        same_sign = (a[MSB] == b_eff[MSB]);
        sign_flip = (sum[MSB] != a[MSB]);
        ovf       = chk_ovf & same_sign & sign_flip;
    end
endmodule

// File: rtl/int_alu_cmp.sv
// Module: less-than comparator under signed or unsigned interpretation.
// The signed case is reduced to the unsigned one by flipping both sign bits.
// The output is 0 or 1, widened to DATA_W.
module int_alu_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    output logic [DATA_W-1:0] lt_word
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] a_bias;
    logic [DATA_W-1:0] b_bias;
    logic              lt;

    // Offset-binary mapping so that one unsigned compare serves both cases.
    always_comb begin
        a_bias      = a;
        b_bias      = b;
        a_bias[MSB] = a[MSB] ^ is_signed;
        b_bias[MSB] = b[MSB] ^ is_signed;
    end

    // Compare and widen to a full word.
    always_comb begin
        lt      = (a_bias < b_bias);
        lt_word = {{(DATA_W-1){1'b0}}, lt};
    end
endmodule

// File: rtl/int_alu_shl.sv
// Module: logarithmic left shifter with zero fill. Stage i shifts by 2**i
// when bit i of the amount is set. Assumes DATA_W is a power of two.
module int_alu_shl #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [0:SH_W];

    // Stage 0 is the unshifted input.
    always_comb begin
        stage[0] = din;
    end

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        // Conditionally shift by 2**i.
        always_comb begin
            stage[i+1] = amt[i] ? (stage[i] << (2**i)) : stage[i];
        end
    end

    // Final stage drives the output.
    always_comb begin
        dout = stage[SH_W];
    end
endmodule

// File: rtl/int_alu.sv
// Module: top of the integer arithmetic and compare unit.
// Decodes the operation code, routes the operands to the adder, comparator and
// shifter, and selects the result. OUT_REG=1 adds one register stage, cleared
// by a synchronous active-low reset. Unused operation codes give zero.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SH_W    = $clog2(DATA_W),
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result,
    output logic              ovf_flag
);
    alu_op_e           op;
    logic [DATA_W-1:0] opnd_b;
    logic              do_sub;
    logic              chk_ovf;
    logic              cmp_signed;
    logic [DATA_W-1:0] as_sum;
    logic              as_ovf;
    logic [DATA_W-1:0] cmp_word;
    logic [DATA_W-1:0] shl_word;
    logic [DATA_W-1:0] comb_res;
    logic              comb_ovf;

    // Cast the raw code to the operation type.
    always_comb begin
        op = alu_op_e'(op_sel);
    end

    // Derive the control lines for the adder and comparator from the code.
    always_comb begin
        do_sub     = (op == OP_SUB) || (op == OP_SUBM);
        chk_ovf    = (op == OP_ADD) || (op == OP_SUB);
        cmp_signed = (op == OP_LTS);
    end

    int_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_imm (use_imm),
        .reg_b   (src_b),
        .imm     (imm16),
        .opnd_b  (opnd_b)
    );

    int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a       (src_a),
        .b       (opnd_b),
        .do_sub  (do_sub),
        .chk_ovf (chk_ovf),
        .sum     (as_sum),
        .ovf     (as_ovf)
    );

    int_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a         (src_a),
        .b         (opnd_b),
        .is_signed (cmp_signed),
        .lt_word   (cmp_word)
    );

    int_alu_shl #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shl (
        .din  (src_a),
        .amt  (shamt),
        .dout (shl_word)
    );

    // Select the result of the decoded operation.
    always_comb begin
        comb_res = '0;
        comb_ovf = 1'b0;
        case (op)
            OP_ADD, OP_ADDM, OP_SUB, OP_SUBM: begin
                comb_res = as_sum;
                comb_ovf = as_ovf;
            end
            OP_LTS, OP_LTU: comb_res = cmp_word;
            OP_SHL:         comb_res = shl_word;
            default: begin
                comb_res = '0;
                comb_ovf = 1'b0;
            end
        endcase
    end

    if (OUT_REG) begin : g_reg
        logic [DATA_W-1:0] res_q;
        logic              ovf_q;

        // Output register stage, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                ovf_q <= 1'b0;
            end else begin
                res_q <= comb_res;
                ovf_q <= comb_ovf;
            end
        end

        // Drive the ports from the register.
        always_comb begin
            result   = res_q;
            ovf_flag = ovf_q;
        end
    end else begin : g_comb
        // Drive the ports straight from the result select.
        always_comb begin
            result   = comb_res;
            ovf_flag = comb_ovf;
        end
    end
endmodule

// File: rtl/int_alu_checker.sv
// Module: assertion checker bound to int_alu. It observes the ports and the
// internal combinational result ahead of the optional register.
module int_alu_checker
    import int_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              shamt_nz,
    input logic [DATA_W-1:0] comb_res,
    input logic              comb_ovf,
    input logic [DATA_W-1:0] result,
    input logic              ovf_flag
);
    localparam int MSB = DATA_W - 1;

    // R3: the modular forms never report overflow.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADDM || op_sel == OP_SUBM) |-> !comb_ovf);

    // R1: a checked-add overflow implies equal operand signs and a flipped result sign.
    a_r1_add_ovf_signs: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADD && comb_ovf) |->
            (src_a[MSB] == opnd_b[MSB]) && (comb_res[MSB] != src_a[MSB]));

    // R2: a checked-subtract overflow implies different operand signs.
    a_r2_sub_ovf_signs: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SUB && comb_ovf) |->
            (src_a[MSB] != opnd_b[MSB]) && (comb_res[MSB] != src_a[MSB]));

    // R5 and R6: the less-than result is 0 or 1.
    a_r5_lt_boolean: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LTS || op_sel == OP_LTU) |-> (comb_res[MSB:1] == '0));

    // R7: a nonzero shift leaves bit 0 clear.
    a_r7_shl_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SHL && shamt_nz) |-> (comb_res[0] == 1'b0));

    // R8: only the checked add and subtract can raise overflow.
    a_r8_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        comb_ovf |-> (op_sel == OP_ADD || op_sel == OP_SUB));

    if (OUT_REG) begin : g_lat
        // R9: the registered outputs carry the previous cycle's result.
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (result == $past(comb_res)) && (ovf_flag == $past(comb_ovf)));
    end else begin : g_same
        // R10: the outputs equal the internal result in the same cycle.
        a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (result == comb_res) && (ovf_flag == comb_ovf));
    end
endmodule

bind int_alu int_alu_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .src_a    (src_a),
    .opnd_b   (opnd_b),
    .shamt_nz (|shamt),
    .comb_res (comb_res),
    .comb_ovf (comb_ovf),
    .result   (result),
    .ovf_flag (ovf_flag)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
// Bench: directed tests for int_alu. The uut instance has the output register;
// uut_comb has none. Inputs change at the falling edge. The combinational copy
// is sampled 1 ns later; the registered copy is sampled at the next falling edge.
module int_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] res_r, res_c;
    logic        ovf_r, ovf_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    int_alu #(.OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
        .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
        .result(res_r), .ovf_flag(ovf_r)
    );

    int_alu #(.OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
        .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
        .result(res_c), .ovf_flag(ovf_c)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one vector; check the combinational copy (R10) and then the registered copy (R9).
    task automatic apply(input string req, input logic [3:0] op, input logic imm_sel,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh,
                         input logic [31:0] exp_res, input logic exp_ovf);
        @(negedge clk);
        op_sel = op; use_imm = imm_sel; src_a = a; src_b = b; imm16 = imm; shamt = sh;
        #1;
        check(req, "R10 comb result", res_c, exp_res);
        check(req, "R10 comb ovf", {31'b0, ovf_c}, {31'b0, exp_ovf});
        @(negedge clk);
        check(req, "R9 reg result", res_r, exp_res);
        check(req, "R9 reg ovf", {31'b0, ovf_r}, {31'b0, exp_ovf});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "reset result", res_r, 32'h0);
        check("R9", "reset ovf", {31'b0, ovf_r}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_r1_add();
        apply("R1", 4'd0, 1'b0, 32'h7fffffff, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b1);
        apply("R1", 4'd0, 1'b0, 32'h80000000, 32'hffffffff, 16'h0, 5'd0, 32'h7fffffff, 1'b1);
        apply("R1", 4'd0, 1'b0, 32'h00000005, 32'hfffffffd, 16'h0, 5'd0, 32'h00000002, 1'b0);
        apply("R1", 4'd0, 1'b0, 32'h7fffffff, 32'h80000000, 16'h0, 5'd0, 32'hffffffff, 1'b0);
    endtask

    task automatic t_r2_sub();
        apply("R2", 4'd2, 1'b0, 32'h80000000, 32'h00000001, 16'h0, 5'd0, 32'h7fffffff, 1'b1);
        apply("R2", 4'd2, 1'b0, 32'h7fffffff, 32'hffffffff, 16'h0, 5'd0, 32'h80000000, 1'b1);
        apply("R2", 4'd2, 1'b0, 32'h00000001, 32'h00000002, 16'h0, 5'd0, 32'hffffffff, 1'b0);
        apply("R2", 4'd2, 1'b0, 32'h80000000, 32'h80000000, 16'h0, 5'd0, 32'h00000000, 1'b0);
    endtask

    task automatic t_r3_modular();
        apply("R3", 4'd1, 1'b0, 32'hffffffff, 32'h00000001, 16'h0, 5'd0, 32'h00000000, 1'b0);
        apply("R3", 4'd1, 1'b0, 32'h7fffffff, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b0);
        apply("R3", 4'd3, 1'b0, 32'h00000000, 32'h00000001, 16'h0, 5'd0, 32'hffffffff, 1'b0);
        apply("R3", 4'd3, 1'b0, 32'h80000000, 32'h00000001, 16'h0, 5'd0, 32'h7fffffff, 1'b0);
    endtask

    task automatic t_r4_immediate();
        apply("R4", 4'd0, 1'b1, 32'h00000000, 32'h12345678, 16'h8000, 5'd0, 32'hffff8000, 1'b0);
        apply("R4", 4'd1, 1'b1, 32'h00000005, 32'hdeadbeef, 16'hffff, 5'd0, 32'h00000004, 1'b0);
        apply("R4", 4'd0, 1'b1, 32'h7fffffff, 32'h00000000, 16'h7fff, 5'd0, 32'h80007ffe, 1'b1);
        apply("R4", 4'd2, 1'b1, 32'h00000010, 32'hffffffff, 16'h0003, 5'd0, 32'h0000000d, 1'b0);
    endtask

    task automatic t_r5_lt_signed();
        apply("R5", 4'd4, 1'b0, 32'hffffffff, 32'h00000001, 16'h0, 5'd0, 32'h1, 1'b0);
        apply("R5", 4'd4, 1'b0, 32'h00000001, 32'hffffffff, 16'h0, 5'd0, 32'h0, 1'b0);
        apply("R5", 4'd4, 1'b0, 32'h80000000, 32'h80000000, 16'h0, 5'd0, 32'h0, 1'b0);
        apply("R5", 4'd4, 1'b1, 32'h00000005, 32'h00000000, 16'hffff, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_r6_lt_unsigned();
        apply("R6", 4'd5, 1'b0, 32'hffffffff, 32'h00000001, 16'h0, 5'd0, 32'h0, 1'b0);
        apply("R6", 4'd5, 1'b0, 32'h00000001, 32'hffffffff, 16'h0, 5'd0, 32'h1, 1'b0);
        apply("R6", 4'd5, 1'b1, 32'h00000005, 32'h00000000, 16'hffff, 5'd0, 32'h1, 1'b0);
        apply("R6", 4'd5, 1'b0, 32'h7fffffff, 32'h7fffffff, 16'h0, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_r7_shift();
        apply("R7", 4'd6, 1'b0, 32'h00000001, 32'h0, 16'h0, 5'd31, 32'h80000000, 1'b0);
        apply("R7", 4'd6, 1'b0, 32'hffffffff, 32'h0, 16'h0, 5'd4, 32'hfffffff0, 1'b0);
        apply("R7", 4'd6, 1'b0, 32'ha5a5a5a5, 32'h0, 16'h0, 5'd0, 32'ha5a5a5a5, 1'b0);
        apply("R7", 4'd6, 1'b0, 32'h00000003, 32'h0, 16'h0, 5'd17, 32'h00060000, 1'b0);
    endtask

    task automatic t_r8_unused();
        for (int c = 7; c < 16; c++)
            apply("R8", 4'(c), 1'b0, 32'h7fffffff, 32'h00000001, 16'h7fff, 5'd3, 32'h0, 1'b0);
    endtask

    // R9: reset held mid-run clears the registered copy while the combinational copy keeps working.
    task automatic t_r9_midreset();
        @(negedge clk);
        op_sel = 4'd0; use_imm = 1'b0; src_a = 32'h7fffffff; src_b = 32'h1; shamt = '0;
        @(negedge clk);
        check("R9", "pre-reset ovf", {31'b0, ovf_r}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "reset result", res_r, 32'h0);
        check("R9", "reset ovf", {31'b0, ovf_r}, 32'h0);
        check("R10", "comb during reset", res_c, 32'h80000000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "post-reset result", res_r, 32'h80000000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_r1_add();
        t_r2_sub();
        t_r3_modular();
        t_r4_immediate();
        t_r5_lt_signed();
        t_r6_lt_unsigned();
        t_r7_shift();
        t_r8_unused();
        t_r9_midreset();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule